// File: doc/BRIEF.md
# Segment Offset Translator with Limit and Privilege Checks

This block turns a segment-relative memory reference into a flat 32-bit linear address. A request names one of a small set of segment slots, gives an offset, says whether it is a read, a write or an instruction fetch, and gives its width in bytes. The block looks up the descriptor held for that slot and adds the segment base to the offset. In the same cycle it checks three things: that the access stays inside the segment, that the caller is privileged enough, and that the segment type allows this kind of access. One cycle later it returns either the address or a fault code.

A separate fetch unit loads the descriptor slots through a write port. Each write supplies a base, a 20-bit limit, a granularity flag, a 16/32-bit offset-size flag, a privilege level, a code/data flag, a writable flag and a usable flag. After reset every slot is marked unusable.

Top module: `seg_xlate`

## Requirements
- R1: One cycle after a request is accepted, `out_valid` is high. With no fault, `out_lin` equals base plus effective offset, wrapped modulo 2^32. When there is no request in a cycle, `out_valid` is low in the next cycle.
- R2: When the descriptor's size flag is 0, the effective offset is the low 16 bits of `req_off`, and the upper 16 bits have no effect. When the flag is 1, all 32 bits are used.
- R3: With granularity 0 the limit is a byte offset. An access whose last byte lies above the limit gives fault code 1 (limit). An access of one byte at offset 0 never gives a limit fault.
- R4: With granularity 1 the effective limit is the 20-bit limit shifted left by 12, with the low 12 bits set to ones.
- R5: `req_len` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The last byte is the effective offset plus the byte count minus 1. This sum is formed without wrapping, so a sum above 0xFFFFFFFF is a limit fault.
- R6: The effective level is the larger of `req_cpl` and `req_rpl`. If it is greater than the descriptor level, the result is fault code 2 (privilege). Level 0 with requested level 0 never gives a privilege fault.
- R7: Fault code 3 (type) results from a write to a code segment, a write to a data segment without the writable flag, or a fetch from a data segment.
- R8: Fault code 3 also results from a request to a slot marked unusable, or to a slot number of `NUM_SEGS` or above.
- R9: When several faults apply, only one is reported. The priority is: unusable slot, then privilege, then access type, then limit.
- R10: A faulted result drives `out_lin` to 0.
- R11: Reset clears `out_valid`, `out_fault` and `out_lin` and marks every slot unusable. While `out_valid` is low, `out_fault` and `out_lin` are 0.
- R12: A descriptor write to slot k takes effect for requests made in later cycles. Writes to slot numbers of `NUM_SEGS` or above change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor slot write enable |
| desc_idx | input | SEG_W | Slot number written |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 20 | Segment limit |
| desc_gran | input | 1 | 1: limit counts 4096-byte units |
| desc_big | input | 1 | 1: 32-bit offsets, 0: 16-bit |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_code | input | 1 | 1: code segment, 0: data |
| desc_wr | input | 1 | Data segment is writable |
| desc_usable | input | 1 | Slot holds a usable segment |
| req_valid | input | 1 | Translation request |
| req_seg | input | SEG_W | Slot used by the request |
| req_off | input | 32 | Offset |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_len | input | 2 | Access size code |
| req_cpl | input | 2 | Current privilege level |
| req_rpl | input | 2 | Requested privilege level |
| out_valid | output | 1 | Result valid |
| out_lin | output | 32 | Linear address |
| out_fault | output | 2 | 0 none, 1 limit, 2 privilege, 3 type |

## Verification
Several properties are checked on every cycle: the fixed one-cycle relation between request and result, the zero address on any fault, the clean outputs while idle, the absence of privilege faults at level 0, and the absence of limit faults on a one-byte access at offset 0. Other behaviours can only be shown by the bench's scenarios, because they depend on stored descriptor contents. These are the correct base sums and their wrap, truncation to 16 bits, the limit edge in both granularities, the type and privilege decisions, the fault priority, and slot rewrites.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W  = 32;
  localparam int LIM_W   = 20;
  localparam int PAGE_SH = 12;
  localparam int SHORT_W = 16;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_LIMIT = 2'd1, FLT_PRIV = 2'd2, FLT_TYPE = 2'd3} flt_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              big;
    logic [1:0]        dpl;
    logic              code;
    logic              wr;
    logic              usable;
  } desc_t;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int SEG_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  desc_t            wr_desc,
  input  logic [SEG_W-1:0] rd_idx,
  output desc_t            rd_desc
);
  localparam logic [SEG_W:0] SLOT_CNT = NUM_SEGS[SEG_W:0];

  desc_t slots [NUM_SEGS];
  logic  wr_in_range, rd_in_range;

  assign wr_in_range = {1'b0, wr_idx} < SLOT_CNT;
  assign rd_in_range = {1'b0, rd_idx} < SLOT_CNT;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEGS; i++) slots[i] <= '0;
    end else if (wr_en && wr_in_range) begin
      slots[wr_idx] <= wr_desc;
    end
  end

  always_comb begin
    rd_desc = '0;
    if (rd_in_range) rd_desc = slots[rd_idx];
  end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
  import seg_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] off,
  input  logic [1:0]        len,
  input  logic [LIM_W-1:0]  limit,
  input  logic              gran,
  input  logic              big,
  output logic [ADDR_W-1:0] eff_off,
  output logic              over
);
  localparam int HI_W = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] eff_limit;
  logic [3:0]        span_m1;
  logic [ADDR_W:0]   last_byte;

  generate
    if (HI_W == PAGE_SH) begin : g_page
      assign eff_limit = gran ? {limit, {PAGE_SH{1'b1}}} : {{HI_W{1'b0}}, limit};
    end else begin : g_page_trim
      logic [LIM_W+PAGE_SH-1:0] wide;
      assign wide      = gran ? {limit, {PAGE_SH{1'b1}}} : {{PAGE_SH{1'b0}}, limit};
      assign eff_limit = wide[ADDR_W-1:0];
    end
  endgenerate

  assign eff_off   = big ? off : {{(ADDR_W-SHORT_W){1'b0}}, off[SHORT_W-1:0]};
  assign span_m1   = (4'd1 << len) - 4'd1;
  assign last_byte = {1'b0, eff_off} + {{(ADDR_W-3){1'b0}}, span_m1};
  assign over      = last_byte > {1'b0, eff_limit};
endmodule

// File: rtl/seg_prot_chk.sv
module seg_prot_chk
  import seg_xlate_pkg::*;
(
  input  desc_t      desc,
  input  acc_e       kind,
  input  logic [1:0] cpl,
  input  logic [1:0] rpl,
  output flt_e       fault
);
  logic [1:0] eff_pl;
  logic       bad_type;

  assign eff_pl   = (cpl > rpl) ? cpl : rpl;
  assign bad_type = (kind == ACC_WRITE && (desc.code || !desc.wr)) ||
                    (kind == ACC_FETCH && !desc.code);

  always_comb begin
    if (!desc.usable)          fault = FLT_TYPE;
    else if (eff_pl > desc.dpl) fault = FLT_PRIV;
    else if (bad_type)          fault = FLT_TYPE;
    else                        fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int SEG_W    = $clog2(NUM_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_we,
  input  logic [SEG_W-1:0]  desc_idx,
  input  logic [31:0]       desc_base,
  input  logic [19:0]       desc_limit,
  input  logic              desc_gran,
  input  logic              desc_big,
  input  logic [1:0]        desc_dpl,
  input  logic              desc_code,
  input  logic              desc_wr,
  input  logic              desc_usable,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [31:0]       req_off,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_len,
  input  logic [1:0]        req_cpl,
  input  logic [1:0]        req_rpl,
  output logic              out_valid,
  output logic [31:0]       out_lin,
  output logic [1:0]        out_fault
);
  desc_t             wr_d, cur_d;
  logic [ADDR_W-1:0] eff_off, lin_next;
  logic              over;
  flt_e              prot_flt, flt_next;

  assign wr_d = '{base: desc_base, limit: desc_limit, gran: desc_gran, big: desc_big,
                  dpl: desc_dpl, code: desc_code, wr: desc_wr, usable: desc_usable};

  seg_desc_cache #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_cache (
    .clk(clk), .rst(rst), .wr_en(desc_we), .wr_idx(desc_idx), .wr_desc(wr_d),
    .rd_idx(req_seg), .rd_desc(cur_d)
  );

  seg_limit_chk u_lim (
    .off(req_off), .len(req_len), .limit(cur_d.limit), .gran(cur_d.gran),
    .big(cur_d.big), .eff_off(eff_off), .over(over)
  );

  seg_prot_chk u_prot (
    .desc(cur_d), .kind(acc_e'(req_kind)), .cpl(req_cpl), .rpl(req_rpl), .fault(prot_flt)
  );

  assign flt_next = (prot_flt != FLT_NONE) ? prot_flt : (over ? FLT_LIMIT : FLT_NONE);
  assign lin_next = cur_d.base + eff_off;

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      out_valid <= 1'b0;
      out_lin   <= '0;
      out_fault <= FLT_NONE;
    end else begin
      out_valid <= 1'b1;
      out_fault <= flt_next;
      out_lin   <= (flt_next == FLT_NONE) ? lin_next : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_off,
  input logic [1:0]  req_len,
  input logic [1:0]  req_cpl,
  input logic [1:0]  req_rpl,
  input logic        out_valid,
  input logic [31:0] out_lin,
  input logic [1:0]  out_fault
);
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  assert_fault_zero_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault != 2'd0) |-> out_lin == 32'd0);

  assert_idle_clean_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_fault == 2'd0 && out_lin == 32'd0));

  assert_level0_no_priv_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cpl == 2'd0 && req_rpl == 2'd0) |=> out_fault != 2'd2);

  assert_first_byte_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_off == 32'd0 && req_len == 2'd0) |=> out_fault != 2'd1);
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W)) u_seg_xlate_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_off(req_off), .req_len(req_len),
  .req_cpl(req_cpl), .req_rpl(req_rpl), .out_valid(out_valid), .out_lin(out_lin),
  .out_fault(out_fault)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int SEG_W = 3;

  logic clk = 0, rst = 1;
  logic desc_we = 0; logic [SEG_W-1:0] desc_idx = 0;
  logic [31:0] desc_base = 0; logic [19:0] desc_limit = 0;
  logic desc_gran = 0, desc_big = 0, desc_code = 0, desc_wr = 0, desc_usable = 0;
  logic [1:0] desc_dpl = 0;
  logic req_valid = 0; logic [SEG_W-1:0] req_seg = 0; logic [31:0] req_off = 0;
  logic [1:0] req_kind = 0, req_len = 0, req_cpl = 0, req_rpl = 0;
  logic out_valid; logic [31:0] out_lin; logic [1:0] out_fault;

  int total = 0, failed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_xlate #(.NUM_SEGS(6)) i_seg_xlate (.*);

  typedef struct packed {
    logic [7:0]  req; logic [2:0] seg; logic [31:0] off; logic [1:0] kind;
    logic [1:0]  len; logic [1:0] cpl; logic [1:0] rpl; logic [1:0] flt; logic [31:0] lin;
  } vec_t;

  // kind: 0 read, 1 write, 2 fetch; fault: 0 none, 1 limit, 2 priv, 3 type
  localparam vec_t VECS [19] = '{
    '{8'd1, 3'd0, 32'h0000_0100, 2'd2, 2'd2, 2'd0, 2'd0, 2'd0, 32'h0001_0100}, // R1 fetch code
    '{8'd7, 3'd0, 32'h0000_0010, 2'd1, 2'd0, 2'd0, 2'd0, 2'd3, 32'h0},         // R7 write code
    '{8'd3, 3'd1, 32'h0000_0FFC, 2'd0, 2'd2, 2'd3, 2'd3, 2'd0, 32'h1000_0FFC}, // R3 edge in
    '{8'd5, 3'd1, 32'h0000_0FFD, 2'd0, 2'd2, 2'd3, 2'd3, 2'd1, 32'h0},         // R5 straddle
    '{8'd3, 3'd1, 32'h0000_1000, 2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 32'h0},         // R3 past limit
    '{8'd4, 3'd2, 32'h0001_0FFF, 2'd0, 2'd0, 2'd3, 2'd3, 2'd0, 32'h2001_0FFF}, // R4 page edge
    '{8'd4, 3'd2, 32'h0001_1000, 2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 32'h0},         // R4 past page
    '{8'd7, 3'd2, 32'h0000_0000, 2'd1, 2'd0, 2'd3, 2'd3, 2'd3, 32'h0},         // R7 read-only
    '{8'd7, 3'd1, 32'h0000_0000, 2'd2, 2'd0, 2'd3, 2'd3, 2'd3, 32'h0},         // R7 fetch data
    '{8'd2, 3'd3, 32'hABCD_1234, 2'd0, 2'd1, 2'd3, 2'd3, 2'd0, 32'h0000_0234}, // R2 + R1 wrap
    '{8'd6, 3'd4, 32'h0000_0000, 2'd0, 2'd0, 2'd3, 2'd0, 2'd2, 32'h0},         // R6 cpl
    '{8'd6, 3'd4, 32'h0000_0000, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 32'h0},         // R6 rpl
    '{8'd6, 3'd4, 32'h0000_0020, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 32'h4000_0020}, // R6 allowed
    '{8'd8, 3'd5, 32'h0000_0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 32'h0},         // R8 unusable
    '{8'd9, 3'd4, 32'hFFFF_FFFF, 2'd1, 2'd3, 2'd3, 2'd3, 2'd2, 32'h0},         // R9 priv>limit
    '{8'd9, 3'd2, 32'h0001_1000, 2'd1, 2'd0, 2'd3, 2'd3, 2'd3, 32'h0},         // R9 type>limit
    '{8'd6, 3'd0, 32'h0000_0000, 2'd2, 2'd0, 2'd3, 2'd3, 2'd2, 32'h0},         // R6 code dpl0
    '{8'd5, 3'd4, 32'hFFFF_FFFC, 2'd0, 2'd3, 2'd0, 2'd0, 2'd1, 32'h0},         // R5 no wrap
    '{8'd8, 3'd6, 32'h0000_0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 32'h0}          // R8 out of range
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_desc(input logic [2:0] idx, input logic [31:0] base, input logic [19:0] lim,
                         input logic g, input logic b, input logic [1:0] dpl,
                         input logic code, input logic wr, input logic usable);
    @(negedge clk);
    desc_we = 1; desc_idx = idx; desc_base = base; desc_limit = lim; desc_gran = g;
    desc_big = b; desc_dpl = dpl; desc_code = code; desc_wr = wr; desc_usable = usable;
    @(negedge clk);
    desc_we = 0;
  endtask

  task automatic issue(input logic [2:0] seg, input logic [31:0] off, input logic [1:0] kind,
                       input logic [1:0] len, input logic [1:0] cpl, input logic [1:0] rpl);
    @(negedge clk);
    req_valid = 1; req_seg = seg; req_off = off; req_kind = kind; req_len = len;
    req_cpl = cpl; req_rpl = rpl;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R11 fault after reset", {30'd0, out_fault}, 32'd0);
    chk("R11 lin after reset", out_lin, 32'd0);
    @(negedge clk); rst = 0;
    issue(3'd0, 32'd0, 2'd0, 2'd0, 2'd0, 2'd0);
    chk("R11 slot unusable after reset", {30'd0, out_fault}, 32'd3);
    @(negedge clk);
    chk("R1 no request no valid", {31'd0, out_valid}, 32'd0);
    chk("R11 idle fault zero", {30'd0, out_fault}, 32'd0);

    wr_desc(3'd0, 32'h0001_0000, 20'hFFFFF, 1, 1, 2'd0, 1, 0, 1);
    wr_desc(3'd1, 32'h1000_0000, 20'h00FFF, 0, 1, 2'd3, 0, 1, 1);
    wr_desc(3'd2, 32'h2000_0000, 20'h00010, 1, 1, 2'd3, 0, 0, 1);
    wr_desc(3'd3, 32'hFFFF_F000, 20'hFFFFF, 0, 0, 2'd3, 0, 1, 1);
    wr_desc(3'd4, 32'h4000_0000, 20'hFFFFF, 1, 1, 2'd0, 0, 1, 1);

    foreach (VECS[i]) begin
      issue(VECS[i].seg, VECS[i].off, VECS[i].kind, VECS[i].len, VECS[i].cpl, VECS[i].rpl);
      chk($sformatf("R%0d vec %0d valid", VECS[i].req, i), {31'd0, out_valid}, 32'd1);
      chk($sformatf("R%0d vec %0d fault", VECS[i].req, i), {30'd0, out_fault}, {30'd0, VECS[i].flt});
      chk($sformatf("R%0d vec %0d lin", VECS[i].req, i), out_lin, VECS[i].lin);
    end

    // R2: upper offset bits ignored in a 16-bit segment
    issue(3'd3, 32'h0000_0010, 2'd0, 2'd0, 2'd3, 2'd3);
    chk("R2 short offset base", out_lin, 32'hFFFF_F010);
    issue(3'd3, 32'hFFFF_0010, 2'd0, 2'd0, 2'd3, 2'd3);
    chk("R2 short offset high bits", out_lin, 32'hFFFF_F010);

    // R12: rewrite slot 5, then write out-of-range slot 7
    wr_desc(3'd5, 32'h5000_0000, 20'h000FF, 0, 1, 2'd3, 0, 1, 1);
    issue(3'd5, 32'h0000_0004, 2'd1, 2'd0, 2'd3, 2'd3);
    chk("R12 rewrite fault", {30'd0, out_fault}, 32'd0);
    chk("R12 rewrite lin", out_lin, 32'h5000_0004);
    wr_desc(3'd7, 32'h7000_0000, 20'hFFFFF, 0, 1, 2'd3, 0, 1, 1);
    issue(3'd5, 32'h0000_0004, 2'd0, 2'd0, 2'd3, 2'd3);
    chk("R12 out-of-range write no alias", out_lin, 32'h5000_0004);
    issue(3'd7, 32'h0000_0004, 2'd0, 2'd0, 2'd0, 2'd0);
    chk("R12 slot 7 still faults", {30'd0, out_fault}, 32'd3);

    // R11: reset clears a loaded slot
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    issue(3'd5, 32'h0000_0004, 2'd0, 2'd0, 2'd0, 2'd0);
    chk("R11 reset clears slot", {30'd0, out_fault}, 32'd3);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule